// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Set-Associative Lookup

This block is the read-lookup path of a set-associative cache whose set is chosen from untranslated virtual-address bits while the stored tags are physical. A request presents a 64-bit virtual address. The word and set fields sit entirely inside the page offset, so translation cannot change them. The block reads every way of the selected set on the request edge. One cycle later the translated physical page number arrives with its own strobe. The block then builds the physical tag and compares it against every way. It registers a hit flag and the addressed word.

A fill port writes one tag and one full line into a chosen way of a chosen set and marks that way valid. An invalidate-all input drops every valid bit at once. The same design covers a direct-mapped cache (one way) and a fully associative cache (one set) through its parameters. Its capacity is line bytes times sets times ways. The defaults are 4 sets, 2 ways, 16-byte lines and 4-byte words, which is 128 bytes. Elaboration stops if the set and offset fields would reach past the page offset.

Top module: `vipt_lookup`

## Requirements
- R1: While reset is held and on the first edge after it, rspValid is low, and every way is invalid after reset, so every lookup misses until a fill.
- R2: With the defaults, VA bits 3:2 pick the word, VA bits 5:4 pick the set, and the compared tag is the physical address bits 63:6, which is {ppn, VA bits 11:6}. VA bits 63:12 have no effect on the result.
- R3: A lookup hits when a valid way of the selected set holds the compared tag. rspData is then the 32-bit word of that way's line picked by the word field, with word 0 at line bits 31:0.
- R4: On a miss, rspHit is 0 and rspData is 0.
- R5: A request sampled at edge k, with ppnValid sampled at edge k+1, gives rspValid high after edge k+1. A request without ppnValid in the next cycle gives no response. A new request may be accepted on every cycle.
- R6: A fill writes its tag and line into the addressed way and sets that way valid. A request sampled at the same edge as the fill still sees the old contents. A request sampled on any later edge sees the new contents.
- R7: invalidate-all clears every valid bit. A lookup whose request edge or compare edge coincides with it misses. When it meets a fill on the same edge, the filled way ends invalid.
- R8: The same virtual address presented with a different physical page number misses (no false hit across address spaces).
- R9: At most one way of a set matches in any compare, and only the matching way's data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqVa | input | 64 | Virtual address of the request |
| ppnValid | input | 1 | Physical page number valid, one cycle after the request |
| ppn | input | 52 | Translated physical page number |
| fillValid | input | 1 | Fill write strobe |
| fillTag | input | 58 | Physical tag to store |
| fillIdx | input | 2 | Set to fill |
| fillWay | input | 1 | Way to fill |
| fillLine | input | 128 | Line data to store |
| invalAll | input | 1 | Clear all valid bits |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Lookup hit |
| rspData | output | 32 | Addressed word on a hit, zero on a miss |

## Verification
The assertions check on every cycle that a response is backed by a request two edges earlier and a page-number strobe one edge earlier, that a miss returns zero data, that the ways never match more than once, that a response coinciding with an invalidate is a miss, and that no response follows reset. Only the bench scenarios can show that the right word comes back from the right way, that upper virtual bits are ignored, and that a changed page number misses. They also show how fills and invalidates are ordered against requests in flight, which needs a model of the array contents.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic capture;  // latch selected set of a new request
    logic respond;  // compare and register a response
    logic fill;     // write one way
    logic clear;    // drop all valid bits
  } vipt_ctl_t;
endpackage

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      ppnValid,
  input  logic      fillValid,
  input  logic      invalAll,
  output vipt_ctl_t ctl,
  output logic      rspValid
);
  logic stagePend;

  always_comb begin
    ctl.capture = reqValid;
    ctl.respond = stagePend && ppnValid;
    ctl.fill    = fillValid;
    ctl.clear   = invalAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagePend <= 1'b0;
      rspValid  <= 1'b0;
    end else begin
      stagePend <= reqValid;
      rspValid  <= ctl.respond;
    end
  end
endmodule

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_BITS  = 12,
  localparam int OFF_BITS  = $clog2(LINE_BYTES),
  localparam int IDX_BITS  = $clog2(SETS),
  localparam int IDX_W     = (IDX_BITS > 0) ? IDX_BITS : 1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_LO    = OFF_BITS + IDX_BITS,
  localparam int TAG_W     = 64 - TAG_LO,
  localparam int PPN_W     = 64 - PAGE_BITS,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int WORD_BITS = $clog2(WORD_BYTES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  vipt_ctl_t         ctl,
  input  logic [63:0]       reqVa,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [LINE_W-1:0] fillLine,
  output logic [WAYS-1:0]   hitVec,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData
);
  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [LINE_W-1:0] lineMem [SETS][WAYS];
  logic [WAYS-1:0]   validMem [SETS];

  logic [IDX_W-1:0]     reqSet;
  logic [TAG_W-1:0]     s1Tag  [WAYS];
  logic [LINE_W-1:0]    s1Line [WAYS];
  logic [WAYS-1:0]      s1Vld;
  logic [PAGE_BITS-1:0] s1PgOff;

  generate
    if (IDX_BITS > 0) begin : g_idx
      assign reqSet = reqVa[OFF_BITS +: IDX_W];
    end else begin : g_noidx
      assign reqSet = '0;
    end
    if (TAG_LO > PAGE_BITS) begin : g_bad
      $error("set and offset fields exceed the page offset");
    end
  endgenerate

  // Array storage: tags and lines carry no reset.
  always_ff @(posedge clk) begin
    if (ctl.fill) begin
      tagMem[fillIdx][fillWay]  <= fillTag;
      lineMem[fillIdx][fillWay] <= fillLine;
    end
  end

  // Valid bits: invalidate wins over a fill on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (ctl.clear) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (ctl.fill) begin
      validMem[fillIdx][fillWay] <= 1'b1;
    end
  end

  // Stage 1: snapshot of the selected set, read with the virtual index.
  always_ff @(posedge clk) begin
    if (ctl.capture) begin
      for (int w = 0; w < WAYS; w++) begin
        s1Tag[w]  <= tagMem[reqSet][w];
        s1Line[w] <= lineMem[reqSet][w];
      end
      s1PgOff <= reqVa[PAGE_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     s1Vld <= '0;
    else if (ctl.capture)          s1Vld <= ctl.clear ? '0 : validMem[reqSet];
    else if (ctl.clear)            s1Vld <= '0;
  end

  // Stage 2: physical tag compare and word select.
  logic [63:0]           physAddr;
  logic [TAG_W-1:0]      lookTag;
  logic [OFF_BITS-WORD_BITS-1:0] wordSel;
  logic [WORD_W-1:0]     selData;

  assign physAddr = {ppn, s1PgOff};
  assign lookTag  = physAddr[63:TAG_LO];
  assign wordSel  = s1PgOff[OFF_BITS-1:WORD_BITS];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hitVec[w] = s1Vld[w] && (s1Tag[w] == lookTag) && !ctl.clear;
    end
  endgenerate

  always_comb begin
    selData = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) selData = selData | s1Line[w][wordSel*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit  <= 1'b0;
      rspData <= '0;
    end else if (ctl.respond) begin
      rspHit  <= |hitVec;
      rspData <= selData;
    end
  end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_BITS  = 12,
  localparam int OFF_BITS  = $clog2(LINE_BYTES),
  localparam int IDX_BITS  = $clog2(SETS),
  localparam int IDX_W     = (IDX_BITS > 0) ? IDX_BITS : 1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W     = 64 - OFF_BITS - IDX_BITS,
  localparam int PPN_W     = 64 - PAGE_BITS,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORD_W    = WORD_BYTES * 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [63:0]       reqVa,
  input  logic              ppnValid,
  input  logic [PPN_W-1:0]  ppn,
  input  logic              fillValid,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              invalAll,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData
);
  vipt_ctl_t       ctl;
  logic [WAYS-1:0] hitVec;

  vipt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ppnValid(ppnValid),
    .fillValid(fillValid), .invalAll(invalAll), .ctl(ctl), .rspValid(rspValid)
  );

  vipt_datapath #(
    .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES), .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqVa(reqVa), .ppn(ppn),
    .fillTag(fillTag), .fillIdx(fillIdx), .fillWay(fillWay), .fillLine(fillLine),
    .hitVec(hitVec), .rspHit(rspHit), .rspData(rspData)
  );
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int WAYS   = 2,
  parameter int WORD_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              ppnValid,
  input logic              invalAll,
  input logic              rspValid,
  input logic              rspHit,
  input logic [WORD_W-1:0] rspData,
  input logic [WAYS-1:0]   hitVec
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !rspValid);

  a_r5_resp_needs_req_and_ppn: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(ppnValid) && $past(reqValid, 2)));

  a_r4_miss_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspData == '0));

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r7_inval_forces_miss: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(invalAll)) |-> !rspHit);
endmodule

bind vipt_lookup vipt_lookup_chk #(.WAYS(WAYS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .ppnValid(ppnValid),
  .invalAll(invalAll), .rspValid(rspValid), .rspHit(rspHit),
  .rspData(rspData), .hitVec(hitVec)
);

// File: tb/tb_vipt_lookup.sv
module tb_vipt_lookup;
  localparam int SETS = 4, WAYS = 2, LINE_W = 128, WORD_W = 32;
  localparam int TAG_W = 58, PPN_W = 52;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, ppnValid = 0, fillValid = 0, invalAll = 0;
  logic [63:0] reqVa = '0;
  logic [PPN_W-1:0] ppn = '0;
  logic [TAG_W-1:0] fillTag = '0;
  logic [1:0] fillIdx = '0;
  logic [0:0] fillWay = '0;
  logic [LINE_W-1:0] fillLine = '0;
  logic rspValid, rspHit;
  logic [WORD_W-1:0] rspData;

  always #10 clk = ~clk;

  vipt_lookup dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .ppnValid(ppnValid), .ppn(ppn), .fillValid(fillValid), .fillTag(fillTag),
    .fillIdx(fillIdx), .fillWay(fillWay), .fillLine(fillLine),
    .invalAll(invalAll), .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData)
  );

  int errors = 0, checks = 0;
  string curReq = "R1";

  // Behavioural model state
  logic [TAG_W-1:0]  mTag  [SETS][WAYS];
  logic [LINE_W-1:0] mLine [SETS][WAYS];
  bit                mVld  [SETS][WAYS];
  bit                m1V;
  logic [TAG_W-1:0]  m1Tag [WAYS];
  logic [LINE_W-1:0] m1Line[WAYS];
  bit                m1Vld [WAYS];
  logic [11:0]       m1Off;
  bit                eV, eHit;
  logic [WORD_W-1:0] eData;

  function automatic logic [63:0] mkVa(logic [51:0] hi, logic [5:0] tl, logic [1:0] st, logic [1:0] wd);
    return {hi, tl, st, wd, 2'b00};
  endfunction

  function automatic logic [LINE_W-1:0] mkLine(logic [31:0] base);
    return {base + 32'd3, base + 32'd2, base + 32'd1, base};
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  // One cycle: drive, advance model, clock, compare.
  task automatic step(bit rq, logic [63:0] va, bit pv, logic [PPN_W-1:0] pn,
                      bit fv, logic [1:0] fIdx, bit fWay, logic [TAG_W-1:0] fTag,
                      logic [LINE_W-1:0] fLn, bit inv);
    logic [63:0] pa;
    int st;
    reqValid = rq; reqVa = va; ppnValid = pv; ppn = pn;
    fillValid = fv; fillIdx = fIdx; fillWay = fWay; fillTag = fTag; fillLine = fLn;
    invalAll = inv;
    // response for the stage-1 entry
    if (m1V && pv) begin
      eV = 1; eHit = 0; eData = '0;
      pa = {pn, m1Off};
      for (int w = 0; w < WAYS; w++)
        if (m1Vld[w] && m1Tag[w] == pa[63:6] && !inv) begin
          eHit = 1; eData = m1Line[w][m1Off[3:2]*32 +: 32];
        end
    end else eV = 0;
    // new stage-1 snapshot
    m1V = rq;
    if (rq) begin
      st = int'(va[5:4]);
      for (int w = 0; w < WAYS; w++) begin
        m1Tag[w] = mTag[st][w]; m1Line[w] = mLine[st][w];
        m1Vld[w] = inv ? 0 : mVld[st][w];
      end
      m1Off = va[11:0];
    end
    // arrays
    if (fv) begin
      mTag[fIdx][fWay] = fTag; mLine[fIdx][fWay] = fLn; mVld[fIdx][fWay] = 1;
    end
    if (inv)
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mVld[s][w] = 0;
    @(posedge clk);
    @(negedge clk);
    check("rspValid", 64'(rspValid), 64'(eV));
    if (eV) begin
      check("rspHit", 64'(rspHit), 64'(eHit));
      check("rspData", 64'(rspData), 64'(eData));
    end
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, '0, 0, '0, '0, 0);
  endtask
  task automatic req(logic [63:0] va);
    step(1, va, 0, '0, 0, '0, 0, '0, '0, 0);
  endtask
  task automatic pnOnly(logic [PPN_W-1:0] pn);
    step(0, '0, 1, pn, 0, '0, 0, '0, '0, 0);
  endtask
  task automatic fill(logic [1:0] s, bit w, logic [TAG_W-1:0] t, logic [LINE_W-1:0] l);
    step(0, '0, 0, '0, 1, s, w, t, l, 0);
  endtask
  task automatic lookup(logic [63:0] va, logic [PPN_W-1:0] pn);
    req(va); pnOnly(pn);
  endtask

  localparam logic [51:0] P1 = 52'h0_1234_5678_9ABC;
  localparam logic [51:0] P2 = 52'h0_0F0F_0F0F_0F0F;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m1V = 0; eV = 0;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mVld[s][w] = 0;
    repeat (3) @(negedge clk);
    check("rspValid in reset", 64'(rspValid), 64'd0);
    rstN = 1;

    // R1: quiet after reset, all ways invalid
    curReq = "R1";
    idle();
    lookup(mkVa(52'h0, 6'h05, 2'd1, 2'd0), P1);

    // R6 + R3: fill, then every word of the line, back to back (R5)
    curReq = "R6";
    fill(2'd1, 0, {P1, 6'h05}, mkLine(32'hA000_0000));
    curReq = "R3";
    req(mkVa(52'h0, 6'h05, 2'd1, 2'd0));
    curReq = "R5";
    step(1, mkVa(52'h0, 6'h05, 2'd1, 2'd1), 1, P1, 0, '0, 0, '0, '0, 0);
    step(1, mkVa(52'h0, 6'h05, 2'd1, 2'd2), 1, P1, 0, '0, 0, '0, '0, 0);
    step(1, mkVa(52'h0, 6'h05, 2'd1, 2'd3), 1, P1, 0, '0, 0, '0, '0, 0);
    pnOnly(P1);

    // R8 + R4: same VA, other page -> miss with zero data
    curReq = "R8";
    lookup(mkVa(52'h0, 6'h05, 2'd1, 2'd2), P2);
    curReq = "R4";
    lookup(mkVa(52'h0, 6'h06, 2'd1, 2'd2), P1);

    // R2: upper virtual bits do not matter
    curReq = "R2";
    lookup(mkVa(52'hF_FFFF_0000_1111, 6'h05, 2'd1, 2'd3), P1);
    lookup(mkVa(52'h0, 6'h05, 2'd2, 2'd3), P1);

    // R9: second way, distinct tag; each returns only its own data
    curReq = "R9";
    fill(2'd1, 1, {P2, 6'h05}, mkLine(32'hB000_0000));
    lookup(mkVa(52'h0, 6'h05, 2'd1, 2'd1), P2);
    lookup(mkVa(52'h0, 6'h05, 2'd1, 2'd1), P1);

    // R5: no page strobe -> no response
    curReq = "R5";
    req(mkVa(52'h0, 6'h05, 2'd1, 2'd0));
    idle();
    idle();

    // R6: fill on the request edge is not seen, later request sees it
    curReq = "R6";
    step(1, mkVa(52'h0, 6'h11, 2'd2, 2'd1), 0, '0, 1, 2'd2, 0, {P1, 6'h11},
         mkLine(32'hC000_0000), 0);
    pnOnly(P1);
    lookup(mkVa(52'h0, 6'h11, 2'd2, 2'd1), P1);
    fill(2'd2, 0, {P2, 6'h11}, mkLine(32'hD000_0000));
    lookup(mkVa(52'h0, 6'h11, 2'd2, 2'd2), P2);

    // R7: invalidate on compare edge, on request edge, and afterwards
    curReq = "R7";
    req(mkVa(52'h0, 6'h05, 2'd1, 2'd0));
    step(0, '0, 1, P1, 0, '0, 0, '0, '0, 1);
    lookup(mkVa(52'h0, 6'h05, 2'd1, 2'd0), P1);
    fill(2'd3, 1, {P1, 6'h22}, mkLine(32'hE000_0000));
    step(1, mkVa(52'h0, 6'h22, 2'd3, 2'd0), 0, '0, 0, '0, 0, '0, '0, 1);
    pnOnly(P1);
    lookup(mkVa(52'h0, 6'h22, 2'd3, 2'd0), P1);
    step(0, '0, 0, '0, 1, 2'd3, 0, {P2, 6'h22}, mkLine(32'hF000_0000), 1);
    lookup(mkVa(52'h0, 6'h22, 2'd3, 2'd0), P2);
    fill(2'd3, 0, {P2, 6'h22}, mkLine(32'hF100_0000));
    lookup(mkVa(52'h0, 6'h22, 2'd3, 2'd3), P2);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule